// File: doc/BRIEF.md
# Modulation Mode Phase Accumulator

This block is the numeric core of a direct digital synthesiser. It keeps a 48-bit phase accumulator that advances by a frequency word on every clock. It adds a phase offset to the top bits of the accumulator and registers the sum as a truncated phase word, which a separate sine lookup turns into an amplitude. The block holds two frequency words, two phase offsets and a sweep step. A two-bit mode input and one asynchronous control line decide which of them are in use.

The control line means something different in each mode. In frequency-shift mode it picks one of the two frequency words. In phase-shift mode it picks one of the two phase offsets. In sweep mode a high level freezes the frequency ramp, and a low level lets the ramp run. In plain tone mode the line is ignored. A state machine decodes the mode and the synchronized control line into seven named states:

- `ST_TONE`
- `ST_FSK_F1`, `ST_FSK_F2`
- `ST_PSK_P1`, `ST_PSK_P2`
- `ST_SWEEP` and `ST_SWEEP_HOLD`

The state register reloads on every clock from the current mode and the synchronized control level. Any state can therefore reach any other state in a single transition. The datapath takes all of its selections from that state register.

Top module: `dds_mod_accum`

## Requirements
- R1: While `rst` is high, `phase_out` is 0 and `phase_valid` is 0. After reset is released, `phase_valid` is 1 from the first rising edge onward. After reset, the state is `ST_TONE` and the frequency register is 0.
- R2: Tone mode is `mode`=0. In this mode the frequency register loads `ftw_a` and the offset `pofs_a` is used. `ctl_in` has no effect on `phase_out`.
- R3: Frequency-shift mode is `mode`=1. If the synchronized control level is low, the frequency register loads `ftw_a` (state `ST_FSK_F1`). If it is high, the register loads `ftw_b` (state `ST_FSK_F2`). The offset used is `pofs_a`.
- R4: Phase-shift mode is `mode`=2. If the synchronized control level is low, `pofs_a` is used (state `ST_PSK_P1`). If it is high, `pofs_b` is used (state `ST_PSK_P2`). The frequency register loads `ftw_a`.
- R5: Sweep mode is `mode`=3. While the synchronized control level is low (state `ST_SWEEP`), the frequency register adds `sweep_step` modulo 2^48 once per clock. The ramp starts from the value the frequency register held when sweep mode was entered. The offset used is `pofs_a`.
- R6: In sweep mode, a high synchronized control level (state `ST_SWEEP_HOLD`) keeps the frequency register at its current value. The phase accumulator keeps advancing by that frozen value.
- R7: The phase accumulator adds the frequency register on every clock, modulo 2^48.
- R8: On each clock, `phase_out` is set to the top 14 bits of the accumulator plus the selected 14-bit offset, modulo 2^14. Both operands are the values held before that edge.
- R9: A level on `ctl_in` sampled at edge k selects the state at edge k+1. The frequency register follows at edge k+2. A new `mode` selects the state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode | input | 2 | 0 tone, 1 frequency shift, 2 phase shift, 3 sweep |
| ctl_in | input | 1 | Asynchronous multifunction control line |
| ftw_a | input | 48 | Frequency word A |
| ftw_b | input | 48 | Frequency word B |
| pofs_a | input | 14 | Phase offset A |
| pofs_b | input | 14 | Phase offset B |
| sweep_step | input | 48 | Per-clock frequency increment in sweep mode |
| phase_out | output | 14 | Truncated phase word for the sine lookup |
| phase_valid | output | 1 | High once `phase_out` carries accumulated data |

## Verification
The assertions assume that `mode`, the frequency words, the offsets and the sweep step are synchronous to `clk`. They treat these as register values that change only between edges. Only `ctl_in` is allowed to arrive at any time. The bench respects this by driving every input at the falling edge. It moves the control line through every mode, including toggling it in tone mode and leaving it high in sweep mode.

// File: rtl/dds_pkg.sv
package dds_pkg;
    typedef enum logic [1:0] {
        MD_TONE  = 2'd0,
        MD_FSK   = 2'd1,
        MD_PSK   = 2'd2,
        MD_SWEEP = 2'd3
    } dds_mode_e;

    typedef enum logic [2:0] {
        ST_TONE,
        ST_FSK_F1,
        ST_FSK_F2,
        ST_PSK_P1,
        ST_PSK_P2,
        ST_SWEEP,
        ST_SWEEP_HOLD
    } dds_state_e;
endpackage

// File: rtl/dds_mode_fsm.sv
module dds_mode_fsm
    import dds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       ctl_in,
    output logic       sel_ftw_b,
    output logic       sel_pofs_b,
    output logic       ramp_step,
    output logic       ramp_hold
);
    logic       ctl_meta;
    dds_state_e state_q;
    dds_state_e state_d;

    // first synchronizer flop; the state register is the second
    always_ff @(posedge clk or posedge rst) begin
        if (rst) ctl_meta <= 1'b0;
        else     ctl_meta <= ctl_in;
    end

    always_comb begin
        unique case (dds_mode_e'(mode))
            MD_TONE:  state_d = ST_TONE;
            MD_FSK:   state_d = ctl_meta ? ST_FSK_F2 : ST_FSK_F1;
            MD_PSK:   state_d = ctl_meta ? ST_PSK_P2 : ST_PSK_P1;
            MD_SWEEP: state_d = ctl_meta ? ST_SWEEP_HOLD : ST_SWEEP;
            default:  state_d = ST_TONE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_TONE;
        else     state_q <= state_d;
    end

    always_comb begin
        sel_ftw_b  = 1'b0;
        sel_pofs_b = 1'b0;
        ramp_step  = 1'b0;
        ramp_hold  = 1'b0;
        unique case (state_q)
            ST_TONE, ST_FSK_F1, ST_PSK_P1: ;
            ST_FSK_F2:     sel_ftw_b  = 1'b1;
            ST_PSK_P2:     sel_pofs_b = 1'b1;
            ST_SWEEP:      ramp_step  = 1'b1;
            ST_SWEEP_HOLD: ramp_hold  = 1'b1;
            default: ;
        endcase
    end

    // R9
    mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> (state_q == ST_TONE));
    // R3
    fsk_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd1) && ctl_meta) |=> sel_ftw_b);
    // R6
    sweep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd3) && ctl_meta) |=> (ramp_hold && !ramp_step));
endmodule

// File: rtl/dds_freq_path.sv
module dds_freq_path #(
    parameter int FTW_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FTW_W-1:0] ftw_a,
    input  logic [FTW_W-1:0] ftw_b,
    input  logic [FTW_W-1:0] sweep_step,
    input  logic             sel_ftw_b,
    input  logic             ramp_step,
    input  logic             ramp_hold,
    output logic [FTW_W-1:0] freq_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)            freq_q <= '0;
        else if (ramp_step) freq_q <= freq_q + sweep_step;
        else if (ramp_hold) freq_q <= freq_q;
        else if (sel_ftw_b) freq_q <= ftw_b;
        else                freq_q <= ftw_a;
    end

    // R5
    ramp_add_chk: assert property (@(posedge clk) disable iff (rst)
        ramp_step |=> (freq_q == $past(freq_q) + $past(sweep_step)));
    // R6
    ramp_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp_hold && !ramp_step) |=> $stable(freq_q));
    // R3
    word_b_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_ftw_b && !ramp_step && !ramp_hold) |=> (freq_q == $past(ftw_b)));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int FTW_W = 48,
    parameter int OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FTW_W-1:0] freq_q,
    input  logic [OUT_W-1:0] pofs_a,
    input  logic [OUT_W-1:0] pofs_b,
    input  logic             sel_pofs_b,
    output logic [OUT_W-1:0] phase_out,
    output logic             phase_valid
);
    localparam int TOP_LO = FTW_W - OUT_W;

    logic [FTW_W-1:0] acc_q;
    logic [OUT_W-1:0] ofs_sel;

    assign ofs_sel = sel_pofs_b ? pofs_b : pofs_a;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            acc_q       <= '0;
            phase_out   <= '0;
            phase_valid <= 1'b0;
        end else begin
            acc_q       <= acc_q + freq_q;
            phase_out   <= acc_q[FTW_W-1:TOP_LO] + ofs_sel;
            phase_valid <= 1'b1;
        end
    end

    // R7
    acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (acc_q == $past(acc_q) + $past(freq_q)));
    // R1
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        phase_valid |=> phase_valid);
    // R8
    out_sum_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase_out == OUT_W'($past(acc_q[FTW_W-1:TOP_LO]) + $past(ofs_sel))));
endmodule

// File: rtl/dds_mod_accum.sv
module dds_mod_accum #(
    parameter int FTW_W = 48,
    parameter int OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             ctl_in,
    input  logic [FTW_W-1:0] ftw_a,
    input  logic [FTW_W-1:0] ftw_b,
    input  logic [OUT_W-1:0] pofs_a,
    input  logic [OUT_W-1:0] pofs_b,
    input  logic [FTW_W-1:0] sweep_step,
    output logic [OUT_W-1:0] phase_out,
    output logic             phase_valid
);
    logic             sel_ftw_b;
    logic             sel_pofs_b;
    logic             ramp_step;
    logic             ramp_hold;
    logic [FTW_W-1:0] freq_q;

    dds_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .ctl_in     (ctl_in),
        .sel_ftw_b  (sel_ftw_b),
        .sel_pofs_b (sel_pofs_b),
        .ramp_step  (ramp_step),
        .ramp_hold  (ramp_hold)
    );

    dds_freq_path #(.FTW_W(FTW_W)) u_freq (
        .clk        (clk),
        .rst        (rst),
        .ftw_a      (ftw_a),
        .ftw_b      (ftw_b),
        .sweep_step (sweep_step),
        .sel_ftw_b  (sel_ftw_b),
        .ramp_step  (ramp_step),
        .ramp_hold  (ramp_hold),
        .freq_q     (freq_q)
    );

    dds_phase_acc #(.FTW_W(FTW_W), .OUT_W(OUT_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .freq_q      (freq_q),
        .pofs_a      (pofs_a),
        .pofs_b      (pofs_b),
        .sel_pofs_b  (sel_pofs_b),
        .phase_out   (phase_out),
        .phase_valid (phase_valid)
    );
endmodule

// File: tb/sim_dds_mod_accum.sv
module sim_dds_mod_accum;
    localparam time CLK_PERIOD = 10ns;
    localparam int  FW = 48;
    localparam int  OW = 14;
    localparam int  NVEC = 12;
    // {mode[1:0], ctl, cycles[7:0]}
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 8'd20},   // R2 tone
        {2'd1, 1'b0, 8'd15},   // R3 word A
        {2'd1, 1'b1, 8'd15},   // R3 word B
        {2'd2, 1'b0, 8'd12},   // R4 offset A
        {2'd2, 1'b1, 8'd12},   // R4 offset B
        {2'd3, 1'b0, 8'd30},   // R5 ramp
        {2'd3, 1'b1, 8'd20},   // R6 held
        {2'd3, 1'b0, 8'd25},   // R5 resume
        {2'd1, 1'b1, 8'd3},    // R9 quick switch
        {2'd2, 1'b0, 8'd3},    // R9 quick switch
        {2'd3, 1'b1, 8'd10},   // R6 hold from word
        {2'd0, 1'b1, 8'd15}    // R2 ctl ignored
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          ctl_in = 1'b0;
    logic [FW-1:0] ftw_a = '0;
    logic [FW-1:0] ftw_b = '0;
    logic [OW-1:0] pofs_a = '0;
    logic [OW-1:0] pofs_b = '0;
    logic [FW-1:0] sweep_step = '0;
    logic [OW-1:0] phase_out;
    logic          phase_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model kept in bench terms
    logic          m_s1, m_ctl, m_val;
    logic [1:0]    m_mode;
    logic [FW-1:0] m_freq, m_acc;
    logic [OW-1:0] m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_mod_accum u0 (
        .clk(clk), .rst(rst), .mode(mode), .ctl_in(ctl_in),
        .ftw_a(ftw_a), .ftw_b(ftw_b), .pofs_a(pofs_a), .pofs_b(pofs_b),
        .sweep_step(sweep_step), .phase_out(phase_out), .phase_valid(phase_valid)
    );

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_s1 <= 1'b0; m_ctl <= 1'b0; m_mode <= 2'd0;
            m_freq <= '0; m_acc <= '0; m_out <= '0; m_val <= 1'b0;
        end else begin
            m_s1   <= ctl_in;
            m_ctl  <= m_s1;
            m_mode <= mode;
            if (m_mode == 2'd3)                m_freq <= m_ctl ? m_freq : m_freq + sweep_step;
            else if (m_mode == 2'd1 && m_ctl)  m_freq <= ftw_b;
            else                               m_freq <= ftw_a;
            m_acc <= m_acc + m_freq;
            m_out <= m_acc[FW-1:FW-OW] + ((m_mode == 2'd2 && m_ctl) ? pofs_b : pofs_a);
            m_val <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [OW:0] act, input logic [OW:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        ftw_a = 48'h0123_4567_89AB; ftw_b = 48'h3000_0000_0007;
        pofs_a = 14'h0155; pofs_b = 14'h2ABC; sweep_step = 48'h0000_1357_9BDF;
        @(negedge clk); @(negedge clk);
        // R1 reset values while held
        check("R1 reset", {phase_valid, phase_out}, 15'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", {14'd0, phase_valid}, 15'd1);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            int bad = 0;
            mode   = VEC[i][10:9];
            ctl_in = VEC[i][8];
            for (int c = 0; c < int'(VEC[i][7:0]); c++) begin
                @(negedge clk);
                if ({phase_valid, phase_out} !== {m_val, m_out}) bad++;
            end
            check($sformatf("R2 R3 R4 R5 R6 R8 R9 vector %0d", i), 15'(bad), 15'd0);
        end

        // R2: toggling ctl in tone mode leaves output on model path
        begin
            int bad = 0;
            mode = 2'd0;
            for (int c = 0; c < 30; c++) begin
                ctl_in = c[0];
                @(negedge clk);
                if (phase_out !== m_out) bad++;
            end
            check("R2 ctl ignored", 15'(bad), 15'd0);
        end

        // R9 latency: ctl high in FSK reaches phase steps only after sync
        begin
            int bad = 0;
            mode = 2'd1; ctl_in = 1'b0;
            repeat (4) @(negedge clk);
            ctl_in = 1'b1;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                ctl_in = c[0];
                if (phase_out !== m_out) bad++;
            end
            check("R9 sync latency", 15'(bad), 15'd0);
        end

        // R7 wrap: frequency all ones, accumulator counts down from 0
        ctl_in = 1'b0; mode = 2'd0; pofs_a = '0; ftw_a = '1;
        do_reset();
        @(negedge clk); @(negedge clk);
        check("R7 pre-wrap", {1'b0, phase_out}, 15'd0);
        @(negedge clk);
        check("R7 wrap", {1'b0, phase_out}, {1'b0, 14'h3FFF});

        // R8 offset wrap modulo 2^14
        pofs_a = 14'h3FFF;
        @(negedge clk);
        check("R8 offset", {1'b0, phase_out}, {1'b0, m_out});

        // R5 R6: sweep wrapping frequency with large step, then hold
        begin
            int bad = 0;
            ftw_a = 48'hFFFF_0000_0000; sweep_step = 48'h0FFF_0000_0001;
            mode = 2'd3;
            for (int c = 0; c < 40; c++) begin
                ctl_in = (c >= 20 && c < 30);
                @(negedge clk);
                if (phase_out !== m_out) bad++;
            end
            check("R5 R6 sweep wrap", 15'(bad), 15'd0);
        end

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        #1;
        check("R1 async reset", {phase_valid, phase_out}, 15'd0);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule